// File: doc/BRIEF.md
# Sleep Wake-Up Sequencer

This block decides when a small processor core sleeps and how it returns to execution. The core runs on a four-phase instruction cycle. The block generates those phases (Q1, Q2, Q3 and Q4) from the input clock and stops them while the core sleeps. A sleep request is taken at the end of the cycle that executes it. During sleep, a rising edge on the external interrupt pin raises the interrupt flag and starts the wake-up.

Crystal-type oscillator modes first wait a fixed oscillator start-up time. The RC mode resumes at once. The instruction that was already fetched runs first. After that, the global interrupt enable decides what comes next. If the enable is set, one dummy cycle follows, ending in a vector load and an automatic clear of the enable. If the enable is clear, execution simply goes on in line.

Top module: `swu_sleep_seq`

## Requirements
- R1: While running, `q_o` is one-hot with bit 0 = Q1 through bit 3 = Q4. It advances one phase per clock in the order Q1, Q2, Q3, Q4, Q1. In reset and in the first cycle after reset it shows Q1, with `run_o` = 1.
- R2: If `sleep_i` = 1 during Q4 and `intf_i` = 0, then from the next clock `run_o` = 0 and `q_o` = 0. They stay there until a wake-up, with `dummy_o` and `pc_vec_o` low.
- R3: If `sleep_i` = 1 during Q4 and `intf_i` = 1, the request is treated as a no-op. The next clock shows `run_o` = 1 with Q1.
- R4: While asleep, `intf_set_o` pulses for exactly the one cycle in which `int_pin_i` is first seen high after being low. A pin that was already high at sleep entry, and stays high, neither sets the flag nor wakes the core.
- R5: With `osc_mode_i` = 0, 1 or 2 (crystal modes), `run_o` stays 0 for exactly `OST_CYCLES` (1024) clocks after the `intf_set_o` cycle. It then rises with Q1.
- R6: With `osc_mode_i` = 3 (RC), `run_o` = 1 with Q1 in the clock right after the `intf_set_o` cycle.
- R7: The first instruction cycle after wake-up is a plain cycle with `dummy_o` = 0. It executes the instruction fetched before sleep.
- R8: If `gie_i` = 1 at the Q4 of that first cycle, the next instruction cycle has `dummy_o` = 1 for all four phases. In its Q4, `pc_vec_o` and `gie_clr_o` are both 1. The cycle after that starts at Q1 with `dummy_o` = 0.
- R9: If `gie_i` = 0 at that Q4, no dummy cycle occurs, and `pc_vec_o` and `gie_clr_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Core is executing a sleep instruction |
| intf_i | input | 1 | Current value of the external interrupt flag |
| gie_i | input | 1 | Current value of the global interrupt enable |
| int_pin_i | input | 1 | External interrupt pin |
| osc_mode_i | input | 2 | Oscillator mode: 0..2 crystal, 3 RC |
| run_o | output | 1 | Phase clock and core enabled |
| q_o | output | 4 | One-hot phase strobes, bit 0 = Q1 |
| pc_vec_o | output | 1 | Load the interrupt vector into the PC |
| dummy_o | output | 1 | Current instruction cycle is a dummy cycle |
| intf_set_o | output | 1 | Set the external interrupt flag |
| gie_clr_o | output | 1 | Clear the global interrupt enable |

## Verification
`intf_set_o` is combinational and appears in the same cycle as the first high sample of the pin. The run enable reacts one clock after a Q4 sleep request. In RC mode the run enable returns one clock after the flag pulse; in crystal mode it returns 1025 clocks after it. Once running, the dummy cycle begins four clocks after the first Q1, and the vector and enable-clear pulses fall on the fourth clock of that dummy cycle. The driver computes each of these absolute cycle numbers when it applies the stimulus and queues an expected output vector for each one. The monitor compares all outputs at the falling edge of exactly that cycle.

// File: rtl/swu_pkg.sv
package swu_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_ASLEEP,
    ST_OSC_WAIT,
    ST_WAKE_EXEC,
    ST_DUMMY
  } swu_state_e;

  localparam logic [1:0] OSC_RC = 2'd3;
endpackage

// File: rtl/swu_phase_gen.sv
module swu_phase_gen #(
  parameter int NPH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  output logic [NPH-1:0] q_o,
  output logic           last_o
);
  localparam int PW = $clog2(NPH);

  logic [PW-1:0] ph_q;

  // phase counter parks at Q1 while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  ph_q <= '0;
    else if (!en_i)               ph_q <= '0;
    else if (ph_q == PW'(NPH-1))  ph_q <= '0;
    else                          ph_q <= ph_q + 1'b1;
  end

  for (genvar g = 0; g < NPH; g++) begin : g_strobe
    assign q_o[g] = en_i && (ph_q == PW'(g));
  end

  assign last_o = en_i && (ph_q == PW'(NPH-1));
endmodule

// File: rtl/swu_edge_det.sv
module swu_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= d_i;
  end

  assign rise_o = d_i && !prev_q;
endmodule

// File: rtl/swu_ost_counter.sv
module swu_ost_counter #(
  parameter int OST_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = $clog2(OST_CYCLES) + 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == CW'(OST_CYCLES-1));
endmodule

// File: rtl/swu_sleep_seq.sv
module swu_sleep_seq
  import swu_pkg::*;
#(
  parameter int OST_CYCLES = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_i,
  input  logic       intf_i,
  input  logic       gie_i,
  input  logic       int_pin_i,
  input  logic [1:0] osc_mode_i,
  output logic       run_o,
  output logic [3:0] q_o,
  output logic       pc_vec_o,
  output logic       dummy_o,
  output logic       intf_set_o,
  output logic       gie_clr_o
);
  swu_state_e state_q, state_d;
  logic       last_ph;
  logic       pin_rise;
  logic       ost_done;
  logic       sleep_ok;

  swu_phase_gen #(.NPH(4)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run_o),
    .q_o    (q_o),
    .last_o (last_ph)
  );

  swu_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (int_pin_i),
    .rise_o (pin_rise)
  );

  swu_ost_counter #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != ST_OSC_WAIT),
    .en_i   (state_q == ST_OSC_WAIT),
    .done_o (ost_done)
  );

  // pending flag turns the request into a no-op
  assign sleep_ok = last_ph && sleep_i && !intf_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:       if (sleep_ok) state_d = ST_ASLEEP;
      ST_ASLEEP:    if (pin_rise) state_d = (osc_mode_i == OSC_RC) ? ST_WAKE_EXEC : ST_OSC_WAIT;
      ST_OSC_WAIT:  if (ost_done) state_d = ST_WAKE_EXEC;
      ST_WAKE_EXEC: begin
        if (sleep_ok)     state_d = ST_ASLEEP;
        else if (last_ph) state_d = gie_i ? ST_DUMMY : ST_RUN;
      end
      ST_DUMMY:     if (last_ph) state_d = ST_RUN;
      default:      state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign run_o      = (state_q == ST_RUN) || (state_q == ST_WAKE_EXEC) || (state_q == ST_DUMMY);
  assign intf_set_o = (state_q == ST_ASLEEP) && pin_rise;
  assign dummy_o    = (state_q == ST_DUMMY);
  assign pc_vec_o   = (state_q == ST_DUMMY) && last_ph;
  assign gie_clr_o  = (state_q == ST_DUMMY) && last_ph;
endmodule

// File: rtl/swu_sleep_seq_chk.sv
module swu_sleep_seq_chk #(
  parameter int OST_CYCLES = 1024
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_i,
  input logic       intf_i,
  input logic [1:0] osc_mode_i,
  input logic       run_o,
  input logic [3:0] q_o,
  input logic       pc_vec_o,
  input logic       dummy_o,
  input logic       intf_set_o
);
  logic [31:0] gap_q;
  logic        xtal_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      xtal_q <= 1'b0;
    end else if (intf_set_o) begin
      gap_q  <= '0;
      xtal_q <= (osc_mode_i != 2'd3);
    end else if (!run_o) begin
      gap_q  <= gap_q + 1;
    end
  end

  AST_Q_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(q_o)); // R1
  AST_Q1_TO_Q2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && q_o[0]) |=> (q_o == 4'b0010)); // R1
  AST_SLEEP_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o[3] && !dummy_o && sleep_i && !intf_i) |=> !run_o); // R2
  AST_ASLEEP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |-> (q_o == 4'b0000 && !dummy_o && !pc_vec_o)); // R2
  AST_NOP_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o[3] && sleep_i && intf_i) |=> (run_o && q_o[0])); // R3
  AST_FLAG_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intf_set_o |-> !run_o); // R4
  AST_XTAL_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !$past(run_o) && xtal_q) |-> (gap_q == OST_CYCLES)); // R5
  AST_RC_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intf_set_o && osc_mode_i == 2'd3) |=> (run_o && q_o[0])); // R6
  AST_VEC_AT_Q4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_vec_o |-> (dummy_o && q_o[3])); // R8
  AST_DUMMY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dummy_o) |-> q_o[0]); // R8
endmodule

bind swu_sleep_seq swu_sleep_seq_chk #(.OST_CYCLES(OST_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sleep_i    (sleep_i),
  .intf_i     (intf_i),
  .osc_mode_i (osc_mode_i),
  .run_o      (run_o),
  .q_o        (q_o),
  .pc_vec_o   (pc_vec_o),
  .dummy_o    (dummy_o),
  .intf_set_o (intf_set_o)
);

// File: tb/swu_sleep_seq_test.sv
`timescale 1ns/1ps
module swu_sleep_seq_test;
  localparam int OST = 1024;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sleep_i = 1'b0;
  logic       intf_i = 1'b0;
  logic       gie_i = 1'b0;
  logic       int_pin_i = 1'b0;
  logic [1:0] osc_mode_i = 2'd0;
  logic       run_o;
  logic [3:0] q_o;
  logic       pc_vec_o, dummy_o, intf_set_o, gie_clr_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int         c;
    logic       run;
    logic [3:0] q;
    logic       dum;
    logic       vec;
    logic       iset;
    logic       gclr;
    string      req;
  } exp_t;

  exp_t sb[$];

  swu_sleep_seq #(.OST_CYCLES(OST)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .intf_i(intf_i),
    .gie_i(gie_i), .int_pin_i(int_pin_i), .osc_mode_i(osc_mode_i),
    .run_o(run_o), .q_o(q_o), .pc_vec_o(pc_vec_o), .dummy_o(dummy_o),
    .intf_set_o(intf_set_o), .gie_clr_o(gie_clr_o)
  );

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic push(input int c, input logic run, input logic [3:0] q,
                      input logic dum, input logic vec, input logic iset,
                      input logic gclr, input string req);
    exp_t e;
    e.c = c; e.run = run; e.q = q; e.dum = dum; e.vec = vec;
    e.iset = iset; e.gclr = gclr; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: compare at the falling edge of the due cycle
  always @(negedge clk_i) begin
    exp_t e;
    while (sb.size() > 0 && sb[0].c <= cyc) begin
      e = sb.pop_front();
      checks++;
      if (e.c != cyc ||
          {run_o, q_o, dummy_o, pc_vec_o, intf_set_o, gie_clr_o} !==
          {e.run, e.q, e.dum, e.vec, e.iset, e.gclr}) begin
        errors++;
        $display("FAIL %s cyc %0d: actual run=%b q=%b dum=%b vec=%b iset=%b gclr=%b expected (cyc %0d) run=%b q=%b dum=%b vec=%b iset=%b gclr=%b",
                 e.req, cyc, run_o, q_o, dummy_o, pc_vec_o, intf_set_o, gie_clr_o,
                 e.c, e.run, e.q, e.dum, e.vec, e.iset, e.gclr);
      end
    end
  end

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic wait_q4();
    do tick(); while (q_o !== 4'b1000);
  endtask

  task automatic nop_case();
    wait_q4();
    sleep_i = 1'b1;
    intf_i  = 1'b1;
    push(cyc, 1, 4'b1000, 0, 0, 0, 0, "R3");
    tick();
    sleep_i = 1'b0;
    intf_i  = 1'b0;
    push(cyc,     1, 4'b0001, 0, 0, 0, 0, "R3");
    push(cyc + 1, 1, 4'b0010, 0, 0, 0, 0, "R3");
    repeat (3) tick();
  endtask

  task automatic sleep_wake(input logic [1:0] mode, input logic gie, input logic pre_high);
    int e, w;
    int_pin_i  = pre_high;
    gie_i      = 1'b0;
    osc_mode_i = mode;
    wait_q4();
    sleep_i = 1'b1;
    push(cyc, 1, 4'b1000, 0, 0, 0, 0, "R1");
    tick();
    sleep_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      push(cyc, 0, 4'b0000, 0, 0, 0, 0, pre_high ? "R4" : "R2");
      tick();
    end
    int_pin_i = 1'b0;
    push(cyc, 0, 4'b0000, 0, 0, 0, 0, "R2");
    tick();
    int_pin_i = 1'b1;
    gie_i     = gie;
    e = cyc;
    push(e, 0, 4'b0000, 0, 0, 1, 0, "R4");
    if (mode == 2'd3) begin
      w = e + 1;
    end else begin
      push(e + 1,   0, 4'b0000, 0, 0, 0, 0, "R5");
      push(e + OST, 0, 4'b0000, 0, 0, 0, 0, "R5");
      w = e + OST + 1;
    end
    for (int k = 0; k < 4; k++)
      push(w + k, 1, 4'(1 << k), 0, 0, 0, 0,
           (k == 0) ? ((mode == 2'd3) ? "R6" : "R5") : "R7");
    for (int k = 0; k < 4; k++)
      push(w + 4 + k, 1, 4'(1 << k), gie, gie && k == 3, 0, gie && k == 3,
           gie ? "R8" : "R9");
    push(w + 8, 1, 4'b0001, 0, 0, 0, 0, gie ? "R8" : "R9");
    tick();
    int_pin_i = 1'b0;
    while (cyc < w + 9) tick();
    gie_i = 1'b0;
  endtask

  initial begin
    int c;
    repeat (3) tick();
    push(cyc, 1, 4'b0001, 0, 0, 0, 0, "R1");
    rst_ni = 1'b1;
    c = cyc;
    push(c + 1, 1, 4'b0010, 0, 0, 0, 0, "R1");
    push(c + 2, 1, 4'b0100, 0, 0, 0, 0, "R1");
    push(c + 3, 1, 4'b1000, 0, 0, 0, 0, "R1");
    push(c + 4, 1, 4'b0001, 0, 0, 0, 0, "R1");
    repeat (6) tick();
    nop_case();
    sleep_wake(2'd0, 1'b1, 1'b0);
    sleep_wake(2'd2, 1'b0, 1'b0);
    sleep_wake(2'd3, 1'b1, 1'b0);
    sleep_wake(2'd3, 1'b0, 1'b1);
    sleep_wake(2'd1, 1'b1, 1'b1);
    repeat (4) tick();
    if (sb.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL R1 scoreboard: actual %0d items left, expected 0", sb.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule